// File: doc/BRIEF.md
# RTC Event Flags and Interrupt Request

This block holds the event status of a real-time clock and decides when the clock requests an interrupt. It sees three kinds of events, each as a one-cycle pulse: a periodic tick, the end of a once-per-second time update, and a status read. On each update-end pulse it compares the current seconds, minutes, hours and day-of-month bytes with the programmed alarm bytes and records an alarm event when they match. A field whose alarm byte carries a don't-care code is left out of the comparison.

Each event has a sticky flag. A set of enables, loaded as one group, decides which flags may raise the summary interrupt bit. The summary bit drives an active-low open-drain pin through an output-enable signal. Reading the status byte returns the flags and clears them for the next poll. Loading the update-transfer-inhibit control at 1 also forces the update interrupt enable to 0, so no update interrupt can be raised while transfers are inhibited.

Top module: `rtc_irq_flags`

## Requirements
- R1: `stat_byte` bit 7 is the summary interrupt bit, bit 6 the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Bits 3 down to 0 always read 0.
- R2: A `per_evt` pulse sets the periodic flag (bit 6), and it shows on the clock edge that samples the pulse.
- R3: Every `upd_evt` pulse sets the update flag (bit 4) at the sampling edge, whatever the enables and the alarm bytes hold.
- R4: On an `upd_evt` pulse the alarm flag (bit 5) is set when every compared alarm field equals its time byte. When any compared field differs, the alarm flag is not set.
- R5: A seconds, minutes or hours alarm byte whose bits 7:6 are both 1 is don't-care and matches any time value.
- R6: A 6-bit day-of-month alarm of 0 is don't-care. Any other value is zero-extended and compared with the 8-bit day byte.
- R7: The summary bit is set at the clock edge where any flag, after that edge, is 1 and its enable (periodic, alarm, update) was already loaded at 1. Once set, it stays set until a status read. `irq_oe` is high exactly while the summary bit is 1.
- R8: A `stat_rd` pulse clears the three flags and the summary bit at the sampling edge, which releases `irq_oe`. The byte shown during the read cycle still holds the values from before the clear.
- R9: An update flag raises the summary bit only when the update enable is 1 and the inhibit control is 0. Loading inhibit at 1 stores the update enable as 0, even when `ctl_uie` is 1 in the same load.
- R10: While `rst_n` is low, all flags, the summary bit and all enables are 0, and `irq_oe` is low.
- R11: When an event pulse and `stat_rd` arrive in the same cycle, the event's flag is set after that edge. The event is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_load | input | 1 | Loads the four control bits below |
| ctl_pie | input | 1 | Periodic interrupt enable value |
| ctl_aie | input | 1 | Alarm interrupt enable value |
| ctl_uie | input | 1 | Update interrupt enable value |
| ctl_inhibit | input | 1 | Update-transfer-inhibit value |
| per_evt | input | 1 | Periodic tick pulse |
| upd_evt | input | 1 | Update-ended pulse |
| stat_rd | input | 1 | Status byte read pulse |
| time_sec | input | 8 | Current seconds byte |
| time_min | input | 8 | Current minutes byte |
| time_hr | input | 8 | Current hours byte |
| time_dom | input | 8 | Current day-of-month byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| alm_dom | input | 6 | Day-of-month alarm field |
| stat_byte | output | 8 | Status byte |
| irq_oe | output | 1 | Drive-low enable for the open-drain interrupt pin |

## Verification
Every result is due one clock edge after its stimulus:
- A flag appears at the edge that samples its pulse.
- A clear takes effect at the edge that samples `stat_rd`.
- The summary bit rises at the edge where the flag becomes visible, but only if its enable was loaded at least one edge earlier. An enable loaded later raises the summary bit one edge after the load.

The bench applies every input just after a rising edge and samples 3 ns later, so each sample sees exactly one edge's update. A cycle-level model in the bench advances on the same edge and is compared with the status byte and `irq_oe` at every falling edge. Directed checks add literal expected bytes for the alarm-code, read-collision and inhibit corner cases.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } flags_t;

    typedef struct packed {
        logic pie;
        logic aie;
        logic uie;
        logic inh;
    } ctl_t;

endpackage

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match #(
    parameter int BYTE_W = 8,
    parameter int N_TIME = 3,
    parameter int DOM_W  = 6
) (
    input  logic [N_TIME-1:0][BYTE_W-1:0] time_f,
    input  logic [N_TIME-1:0][BYTE_W-1:0] alarm_f,
    input  logic [BYTE_W-1:0]             time_dom,
    input  logic [DOM_W-1:0]              alarm_dom,
    output logic                          hit
);
    localparam int DC_W = 2;

    logic [N_TIME-1:0] field_ok;
    logic              dom_ok;

    // Per time field: match, or the top two bits mark it don't-care.
    for (genvar i = 0; i < N_TIME; i++) begin : g_field
        logic dc;
        always_comb begin
            dc          = &alarm_f[i][BYTE_W-1 -: DC_W];
            field_ok[i] = dc || (alarm_f[i] == time_f[i]);
        end
    end

    // Day-of-month: a zero field is don't-care, otherwise zero-extend and compare.
    always_comb begin
        dom_ok = (alarm_dom == '0) || (BYTE_W'(alarm_dom) == time_dom);
        hit    = dom_ok && (&field_ok);
    end

endmodule

// File: rtl/rtc_irq_ctl.sv
`timescale 1ns/1ps
module rtc_irq_ctl
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_load,
    input  logic ctl_pie,
    input  logic ctl_aie,
    input  logic ctl_uie,
    input  logic ctl_inhibit,
    output logic pie_en,
    output logic aie_en,
    output logic uie_en
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_load) begin
            ctl_d.pie = ctl_pie;
            ctl_d.aie = ctl_aie;
            ctl_d.inh = ctl_inhibit;
            // Inhibit forces the update enable off.
            ctl_d.uie = ctl_uie && !ctl_inhibit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        pie_en = ctl_q.pie;
        aie_en = ctl_q.aie;
        uie_en = ctl_q.uie && !ctl_q.inh;
    end

endmodule

// File: rtl/rtc_flag_bank.sv
`timescale 1ns/1ps
module rtc_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   per_evt,
    input  logic   upd_evt,
    input  logic   alarm_hit,
    input  logic   stat_rd,
    input  logic   pie_en,
    input  logic   aie_en,
    input  logic   uie_en,
    output flags_t flags,
    output logic   intf
);
    typedef struct packed {
        flags_t fl;
        logic   intf;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // A new event wins over a same-cycle read.
        bank_d.fl.pf = per_evt || (bank_q.fl.pf && !stat_rd);
        bank_d.fl.af = (upd_evt && alarm_hit) || (bank_q.fl.af && !stat_rd);
        bank_d.fl.uf = upd_evt || (bank_q.fl.uf && !stat_rd);
        bank_d.intf  = (bank_d.fl.pf && pie_en)
                    || (bank_d.fl.af && aie_en)
                    || (bank_d.fl.uf && uie_en)
                    || (bank_q.intf && !stat_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        flags = bank_q.fl;
        intf  = bank_q.intf;
    end

endmodule

// File: rtl/rtc_irq_flags.sv
`timescale 1ns/1ps
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DOM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_load,
    input  logic              ctl_pie,
    input  logic              ctl_aie,
    input  logic              ctl_uie,
    input  logic              ctl_inhibit,
    input  logic              per_evt,
    input  logic              upd_evt,
    input  logic              stat_rd,
    input  logic [BYTE_W-1:0] time_sec,
    input  logic [BYTE_W-1:0] time_min,
    input  logic [BYTE_W-1:0] time_hr,
    input  logic [BYTE_W-1:0] time_dom,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hr,
    input  logic [DOM_W-1:0]  alm_dom,
    output logic [BYTE_W-1:0] stat_byte,
    output logic              irq_oe
);
    localparam int N_TIME = 3;
    localparam int LOW_W  = BYTE_W - 4;

    logic [N_TIME-1:0][BYTE_W-1:0] time_f;
    logic [N_TIME-1:0][BYTE_W-1:0] alarm_f;
    logic   hit;
    logic   pie_en, aie_en, uie_en;
    flags_t flags;
    logic   intf;

    always_comb begin
        time_f  = {time_hr, time_min, time_sec};
        alarm_f = {alm_hr, alm_min, alm_sec};
    end

    rtc_alarm_match #(
        .BYTE_W (BYTE_W),
        .N_TIME (N_TIME),
        .DOM_W  (DOM_W)
    ) u_match (
        .time_f    (time_f),
        .alarm_f   (alarm_f),
        .time_dom  (time_dom),
        .alarm_dom (alm_dom),
        .hit       (hit)
    );

    rtc_irq_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_load    (ctl_load),
        .ctl_pie     (ctl_pie),
        .ctl_aie     (ctl_aie),
        .ctl_uie     (ctl_uie),
        .ctl_inhibit (ctl_inhibit),
        .pie_en      (pie_en),
        .aie_en      (aie_en),
        .uie_en      (uie_en)
    );

    rtc_flag_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_evt   (per_evt),
        .upd_evt   (upd_evt),
        .alarm_hit (hit),
        .stat_rd   (stat_rd),
        .pie_en    (pie_en),
        .aie_en    (aie_en),
        .uie_en    (uie_en),
        .flags     (flags),
        .intf      (intf)
    );

    always_comb begin
        stat_byte = {intf, flags.pf, flags.af, flags.uf, {LOW_W{1'b0}}};
        irq_oe    = intf;
    end

endmodule

// File: rtl/rtc_irq_flags_chk.sv
`timescale 1ns/1ps
module rtc_irq_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       per_evt,
    input logic       upd_evt,
    input logic       stat_rd,
    input logic       ctl_load,
    input logic [7:0] stat_byte,
    input logic       irq_oe
);
    AST_PF_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> stat_byte[6]); // R2

    AST_UF_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> stat_byte[4]); // R3

    AST_AF_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_byte[5]) |-> $past(upd_evt)); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !per_evt && !upd_evt) |=> (stat_byte[7:4] == 4'h0)); // R8

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe) |-> (stat_byte[6] || stat_byte[5] || stat_byte[4])); // R7

    AST_HELD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !per_evt && !upd_evt && !ctl_load) |=> $stable(stat_byte[6:4])); // R11

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (stat_byte == 8'h00 && !irq_oe)); // R10
endmodule

bind rtc_irq_flags rtc_irq_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_evt   (per_evt),
    .upd_evt   (upd_evt),
    .stat_rd   (stat_rd),
    .ctl_load  (ctl_load),
    .stat_byte (stat_byte),
    .irq_oe    (irq_oe)
);

// File: tb/rtc_irq_flags_bench.sv
`timescale 1ns/1ps
module rtc_irq_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_load = 0, ctl_pie = 0, ctl_aie = 0, ctl_uie = 0, ctl_inhibit = 0;
    logic       per_evt = 0, upd_evt = 0, stat_rd = 0;
    logic [7:0] time_sec = 0, time_min = 0, time_hr = 0, time_dom = 0;
    logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
    logic [5:0] alm_dom = 0;
    logic [7:0] stat_byte;
    logic       irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_irq_flags u_rtc_irq_flags (
        .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_pie(ctl_pie),
        .ctl_aie(ctl_aie), .ctl_uie(ctl_uie), .ctl_inhibit(ctl_inhibit),
        .per_evt(per_evt), .upd_evt(upd_evt), .stat_rd(stat_rd),
        .time_sec(time_sec), .time_min(time_min), .time_hr(time_hr), .time_dom(time_dom),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr), .alm_dom(alm_dom),
        .stat_byte(stat_byte), .irq_oe(irq_oe)
    );

    // Expected alarm match, from R4, R5 and R6.
    function automatic logic alarm_expect(input logic [7:0] s, m, h, d,
                                          input logic [7:0] as, am, ah,
                                          input logic [5:0] ad);
        logic ok_s, ok_m, ok_h, ok_d;
        ok_s = (as[7:6] == 2'b11) || (as == s);
        ok_m = (am[7:6] == 2'b11) || (am == m);
        ok_h = (ah[7:6] == 2'b11) || (ah == h);
        ok_d = (ad == 6'd0) || ({2'b00, ad} == d);
        return ok_s && ok_m && ok_h && ok_d;
    endfunction

    // Cycle model of the requirements.
    logic m_pf, m_af, m_uf, m_intf, m_pie, m_aie, m_uie, m_inh;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_pf, m_af, m_uf, m_intf, m_pie, m_aie, m_uie, m_inh} <= '0;
        end else begin
            logic npf, naf, nuf;
            npf = per_evt || (m_pf && !stat_rd);
            naf = (upd_evt && alarm_expect(time_sec, time_min, time_hr, time_dom,
                                           alm_sec, alm_min, alm_hr, alm_dom))
                  || (m_af && !stat_rd);
            nuf = upd_evt || (m_uf && !stat_rd);
            m_pf <= npf;
            m_af <= naf;
            m_uf <= nuf;
            m_intf <= (npf && m_pie) || (naf && m_aie) || (nuf && m_uie && !m_inh)
                      || (m_intf && !stat_rd);
            if (ctl_load) begin
                m_pie <= ctl_pie;
                m_aie <= ctl_aie;
                m_inh <= ctl_inhibit;
                m_uie <= ctl_uie && !ctl_inhibit;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("R1 low nibble", {4'h0, stat_byte[3:0]}, 8'h00);
            chk("R2 periodic flag", {7'h0, stat_byte[6]}, {7'h0, m_pf});
            chk("R4 alarm flag", {7'h0, stat_byte[5]}, {7'h0, m_af});
            chk("R3 update flag", {7'h0, stat_byte[4]}, {7'h0, m_uf});
            chk("R7 summary bit", {7'h0, stat_byte[7]}, {7'h0, m_intf});
            chk("R7 irq_oe", {7'h0, irq_oe}, {7'h0, m_intf});
        end
    end

    task automatic cyc();
        @(posedge clk);
        #3;
        per_evt = 0; upd_evt = 0; stat_rd = 0; ctl_load = 0;
    endtask

    task automatic load(input logic p, a, u, i);
        ctl_pie = p; ctl_aie = a; ctl_uie = u; ctl_inhibit = i; ctl_load = 1;
        cyc();
    endtask

    task automatic rd();
        stat_rd = 1;
        cyc();
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk("R10 reset state", stat_byte, 8'h00);
        chk("R10 reset irq", {7'h0, irq_oe}, 8'h00);
        rst_n = 1;
        cyc();

        per_evt = 1; cyc();
        chk("R2 tick sets PF", stat_byte, 8'h40);
        chk("R8 byte before clear", stat_byte, 8'h40);
        rd();
        chk("R8 read clears", stat_byte, 8'h00);
        per_evt = 1; cyc();
        per_evt = 1; stat_rd = 1; cyc();
        chk("R11 tick with read", stat_byte, 8'h40);
        rd();

        time_sec = 8'h30; time_min = 8'h15; time_hr = 8'h08; time_dom = 8'h12;
        alm_sec = 8'h30; alm_min = 8'h15; alm_hr = 8'h08; alm_dom = 6'h12;
        upd_evt = 1; cyc();
        chk("R4 full match", stat_byte, 8'h30);
        rd();
        alm_min = 8'h16;
        upd_evt = 1; cyc();
        chk("R4 minute mismatch", stat_byte, 8'h10);
        rd();
        alm_min = 8'hC0;
        upd_evt = 1; cyc();
        chk("R5 minute dont-care", stat_byte, 8'h30);
        rd();
        time_dom = 8'h05; alm_dom = 6'd0;
        upd_evt = 1; cyc();
        chk("R6 day dont-care", stat_byte, 8'h30);
        rd();
        alm_dom = 6'h06;
        upd_evt = 1; cyc();
        chk("R6 day mismatch", stat_byte, 8'h10);
        rd();

        alm_dom = 6'd0;
        load(0, 1, 0, 0);
        upd_evt = 1; cyc();
        chk("R7 alarm interrupt", stat_byte, 8'hB0);
        chk("R7 irq driven", {7'h0, irq_oe}, 8'h01);
        rd();
        chk("R8 irq released", {7'h0, irq_oe}, 8'h00);

        alm_sec = 8'h31;
        load(0, 0, 1, 0);
        upd_evt = 1; cyc();
        chk("R9 update interrupt", stat_byte, 8'h90);
        rd();
        load(0, 0, 1, 1);
        upd_evt = 1; cyc();
        chk("R9 inhibit blocks update irq", stat_byte, 8'h10);
        load(0, 0, 1, 0);
        chk("R9 no irq at load edge", stat_byte, 8'h10);
        cyc();
        chk("R7 late enable raises summary", stat_byte, 8'h90);
        per_evt = 1; cyc();
        rst_n = 0; #1;
        chk("R10 mid-run reset", stat_byte, 8'h00);
        cyc();
        rst_n = 1;
        cyc();

        void'($urandom(32'd4242));
        for (int n = 0; n < 6000; n++) begin
            time_sec = 8'($urandom % 4);
            time_min = 8'($urandom % 4);
            time_hr  = 8'($urandom % 3);
            time_dom = 8'($urandom % 4);
            case ($urandom % 3)
                0: alm_sec = time_sec;
                1: alm_sec = 8'hC0 | 8'($urandom % 64);
                default: alm_sec = 8'($urandom % 4);
            endcase
            case ($urandom % 3)
                0: alm_min = time_min;
                1: alm_min = 8'hC0 | 8'($urandom % 64);
                default: alm_min = 8'($urandom % 4);
            endcase
            alm_hr  = ($urandom % 2 == 0) ? time_hr : 8'hC0 | 8'($urandom % 64);
            alm_dom = 6'($urandom % 4);
            per_evt = ($urandom % 5 == 0);
            upd_evt = ($urandom % 4 == 0);
            stat_rd = ($urandom % 6 == 0);
            if ($urandom % 20 == 0) begin
                ctl_load = 1;
                ctl_pie = 1'($urandom); ctl_aie = 1'($urandom);
                ctl_uie = 1'($urandom); ctl_inhibit = 1'($urandom);
            end
            cyc();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule